// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor. Input 0 has the highest priority and input 7 the lowest. Software reaches the block through a byte-wide port with two addresses: the command address (0) and the data address (1). A short word sequence initializes the block: one command word, then three data words. Operation commands then select which register a command-address read returns and retire serviced levels one at a time. Data-address writes set the mask.

A rising edge on an input latches a request. The request then stays pending while the line is held high. When the processor acknowledges, the block returns a vector byte: the upper bits of a programmed base, with the level in the low three bits. In the same cycle the winning request moves to the in-service set, unless automatic end-of-interrupt is enabled. The cascade word from initialization is presented on an output pin. A neighbouring controller in a two-level arrangement can decode either form from that pin: the bitmask of the slave input on a master, or the 3-bit identity on a slave.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register is 0xFF, the pending and in-service registers are 0, command-address reads return the pending register, and `int_out` is 0.
- R2: A command-address write with bit 4 set starts initialization. It clears the pending and in-service registers, selects pending-register readback and clears automatic end-of-interrupt. The next three data-address writes load, in order, the vector base, the cascade word and the mode word. The mask register is not changed by any of these.
- R3: Outside initialization, a data-address write loads the mask register; a set bit masks that input. A data-address read returns the mask register.
- R4: A pending bit is set by a rising edge on its input and stays set while the input stays high. It clears in the cycle after the input is low, or when it is acknowledged. It is latched whether or not the input is masked.
- R5: `int_out` is 1 exactly when some pending, unmasked level k exists with no in-service bit at level k or any higher-priority level. Level 0 is the highest priority.
- R6: When `ack` is high and a request qualifies under R5, `vec_out` is {base[7:3], level} for the highest-priority such level. At the clock edge that level's pending bit clears and its in-service bit sets.
- R7: When `ack` is high and no request qualifies, `vec_out` is {base[7:3], 3'd7} and no register bit changes because of the acknowledge.
- R8: Command write 0x0B selects in-service readback and 0x0A selects pending readback for later command-address reads.
- R9: Command write 0x60+n (n from 0 to 7) clears in-service bit n only.
- R10: With mode word bit 1 set, an acknowledge clears the pending bit but leaves the in-service register unchanged.
- R11: `casc_cfg` shows the cascade word loaded during initialization (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request lines, bit 0 highest priority |
| ack | input | 1 | Acknowledge cycle strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte, valid while `ack` is high |
| casc_cfg | output | 8 | Programmed cascade word |

## Verification
A stale in-service bit shows up the next cycle: `int_out` stays low for every pending level at or below it, and the bit is also visible on an in-service readback. A request latched wrongly, or missed, changes `int_out` one cycle after the input edge. It also changes the next acknowledge vector, which then names the wrong level or takes the spurious level 7. A data write absorbed by the wrong register shows up as a wrong mask read on the very next read.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_N  = 8;
  localparam int PIC_LW = $clog2(PIC_N);
  localparam int INIT_BIT = 4;
  localparam int AEOI_BIT = 1;
  localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
  localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
  localparam logic [2:0] EOI_OP = 3'b011;

  typedef logic [PIC_N-1:0] pic_vec_t;
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_st_t;

  // index of the lowest set bit (highest priority); 0 when empty
  function automatic logic [PIC_LW-1:0] first_set(pic_vec_t v);
    logic [PIC_LW-1:0] idx;
    idx = '0;
    for (int i = PIC_N - 1; i >= 0; i--)
      if (v[i]) idx = PIC_LW'(i);
    return idx;
  endfunction

  function automatic pic_vec_t lvl_mask(logic [PIC_LW-1:0] lvl);
    return pic_vec_t'(1) << lvl;
  endfunction

  function automatic logic [7:0] make_vector(logic [7:0] base, logic [PIC_LW-1:0] lvl);
    return {base[7:PIC_LW], lvl};
  endfunction
endpackage

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output pic_vec_t   imr_q,
  output logic [7:0] base_q,
  output logic [7:0] casc_q,
  output logic       aeoi_q,
  output logic       sel_isr_q,
  output logic       init_evt,
  output logic       eoi_evt,
  output logic [PIC_LW-1:0] eoi_lvl
);
  init_st_t st_q;
  logic cmd_wr, dat_wr, run;

  assign cmd_wr   = wr_en && !addr;
  assign dat_wr   = wr_en && addr;
  assign run      = (st_q == ST_RUN);
  assign init_evt = cmd_wr && wdata[INIT_BIT];
  assign eoi_evt  = cmd_wr && run && (wdata[7:5] == EOI_OP) && (wdata[4:3] == 2'b00);
  assign eoi_lvl  = wdata[PIC_LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      imr_q     <= '1;
      base_q    <= '0;
      casc_q    <= '0;
      aeoi_q    <= 1'b0;
      sel_isr_q <= 1'b0;
    end else if (init_evt) begin
      st_q      <= ST_BASE;
      aeoi_q    <= 1'b0;
      sel_isr_q <= 1'b0;
    end else if (cmd_wr && run) begin
      if (wdata == CMD_SEL_IRR) sel_isr_q <= 1'b0;
      if (wdata == CMD_SEL_ISR) sel_isr_q <= 1'b1;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_RUN:  imr_q <= wdata;
        ST_BASE: begin base_q <= wdata; st_q <= ST_CASC; end
        ST_CASC: begin casc_q <= wdata; st_q <= ST_MODE; end
        ST_MODE: begin aeoi_q <= wdata[AEOI_BIT]; st_q <= ST_RUN; end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  AST_INIT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !run) |=> $stable(imr_q)); // R2
  AST_RUN_DATA_LOADS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && run && !cmd_wr) |=> (imr_q == $past(wdata))); // R3
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  pic_vec_t          irr,
  input  pic_vec_t          isr,
  input  pic_vec_t          imr,
  output logic              pend_ok,
  output logic [PIC_LW-1:0] pend_lvl
);
  pic_vec_t req;
  logic [PIC_LW-1:0] svc_lvl;

  assign req      = irr & ~imr;
  assign pend_lvl = first_set(req);
  assign svc_lvl  = first_set(isr);
  assign pend_ok  = (|req) && ((isr == '0) || (pend_lvl < svc_lvl));
endmodule

// File: rtl/pic_status.sv
module pic_status
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pic_vec_t          irq_in,
  input  logic              ack,
  input  logic              pend_ok,
  input  logic [PIC_LW-1:0] pend_lvl,
  input  logic              aeoi,
  input  logic              init_evt,
  input  logic              eoi_evt,
  input  logic [PIC_LW-1:0] eoi_lvl,
  output pic_vec_t          irr_q,
  output pic_vec_t          isr_q
);
  pic_vec_t prev_q, rise, take_mask, eoi_mask;
  logic take_evt;

  assign rise      = irq_in & ~prev_q;
  assign take_evt  = ack && pend_ok;
  assign take_mask = take_evt ? lvl_mask(pend_lvl) : '0;
  assign eoi_mask  = eoi_evt ? lvl_mask(eoi_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      if (init_evt) begin
        irr_q <= '0;
        isr_q <= '0;
      end else begin
        irr_q <= ((irr_q | rise) & irq_in) & ~take_mask;
        isr_q <= (isr_q & ~eoi_mask) | (aeoi ? '0 : take_mask);
      end
    end
  end

  AST_IRR_DROPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in != '1) |=> ((irr_q & ~$past(irq_in)) == '0)); // R4
  AST_ACK_MOVES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !aeoi && !init_evt) |=> ((isr_q & $past(take_mask)) != '0)); // R6
  AST_SPURIOUS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pend_ok && !eoi_evt && !init_evt) |=> (isr_q == $past(isr_q))); // R7
  AST_EOI_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && !take_evt) |=> ((isr_q & $past(eoi_mask)) == '0)); // R9
  AST_AEOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && aeoi && !eoi_evt && !init_evt) |=> (isr_q == $past(isr_q))); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic       ack,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic [7:0] casc_cfg
);
  pic_vec_t imr_q, irr_q, isr_q;
  logic [7:0] base_q;
  logic aeoi_q, sel_isr_q, init_evt, eoi_evt, pend_ok;
  logic [PIC_LW-1:0] eoi_lvl, pend_lvl;

  pic_cmd_port u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .imr_q(imr_q), .base_q(base_q), .casc_q(casc_cfg), .aeoi_q(aeoi_q),
    .sel_isr_q(sel_isr_q), .init_evt(init_evt), .eoi_evt(eoi_evt), .eoi_lvl(eoi_lvl)
  );

  pic_resolver u_res (
    .irr(irr_q), .isr(isr_q), .imr(imr_q), .pend_ok(pend_ok), .pend_lvl(pend_lvl)
  );

  pic_status u_stat (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .pend_ok(pend_ok),
    .pend_lvl(pend_lvl), .aeoi(aeoi_q), .init_evt(init_evt), .eoi_evt(eoi_evt),
    .eoi_lvl(eoi_lvl), .irr_q(irr_q), .isr_q(isr_q)
  );

  assign int_out = pend_ok;
  assign vec_out = make_vector(base_q, pend_ok ? pend_lvl : '1);
  assign rdata   = addr ? imr_q : (sel_isr_q ? isr_q : irr_q);

  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~imr_q) != '0)); // R5
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, casc_cfg;
  logic int_out;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_irr, m_isr, m_imr, m_base, m_casc, m_prev;
  bit m_sel, m_aeoi;
  int m_st;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out),
    .vec_out(vec_out), .casc_cfg(casc_cfg)
  );

  // winning level, -1 when nothing qualifies (scan from top priority down)
  function automatic int exp_lvl();
    for (int k = 0; k < 8; k++) begin
      if (m_isr[k]) return -1;
      if (m_irr[k] && !m_imr[k]) return k;
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] irq, input bit wr, input bit a,
                      input logic [7:0] d, input bit ak);
    int l;
    logic [7:0] nirr, nisr;
    string tag;
    @(negedge clk);
    irq_in = irq; wr_en = wr; addr = a; wdata = d; ack = ak;
    #1;
    l = exp_lvl();
    chk("R5 int_out", {7'b0, int_out}, {7'b0, l >= 0});
    if (ak) begin
      tag = (l >= 0) ? "R6 vector" : "R7 spurious vector";
      chk(tag, vec_out, {m_base[7:3], (l >= 0) ? 3'(l) : 3'd7});
    end
    if (!wr) begin
      if (a) tag = (m_st != 0) ? "R2 mask during init" : "R3 mask read";
      else tag = m_sel ? "R8 in-service readback" : "R4 pending readback";
      chk(tag, rdata, a ? m_imr : (m_sel ? m_isr : m_irr));
    end
    chk("R11 cascade word", casc_cfg, m_casc);
    nirr = (m_irr | (irq & ~m_prev)) & irq;
    nisr = m_isr;
    if (ak && l >= 0) begin
      nirr[l] = 1'b0;
      if (!m_aeoi) nisr[l] = 1'b1;
    end
    if (wr && !a) begin
      if (d[4]) begin
        m_st = 1; nisr = '0; nirr = '0; m_sel = 0; m_aeoi = 0;
      end else if (m_st == 0) begin
        if (d[7:5] == 3'b011 && !d[3]) nisr[d[2:0]] = 1'b0;
        else if (d == 8'h0A) m_sel = 0;
        else if (d == 8'h0B) m_sel = 1;
      end
    end
    if (wr && a) begin
      case (m_st)
        0: m_imr = d;
        1: begin m_base = d; m_st = 2; end
        2: begin m_casc = d; m_st = 3; end
        default: begin m_aeoi = d[1]; m_st = 0; end
      endcase
    end
    m_irr = nirr; m_isr = nisr; m_prev = irq;
  endtask

  task automatic do_init(input logic [7:0] irq, input logic [7:0] base,
                         input logic [7:0] casc, input logic [7:0] mode);
    step(irq, 1, 0, 8'h11, 0);
    step(irq, 0, 1, 8'h00, 0);   // R2: mask readable and unchanged mid-sequence
    step(irq, 1, 1, base, 0);
    step(irq, 1, 1, casc, 0);
    step(irq, 1, 1, mode, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] irq;
    m_irr = '0; m_isr = '0; m_imr = 8'hFF; m_base = '0; m_casc = '0; m_prev = '0;
    m_sel = 0; m_aeoi = 0; m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    addr = 1'b1; #1;
    chk("R1 reset mask", rdata, 8'hFF);
    chk("R1 reset int_out", {7'b0, int_out}, 8'h00);
    addr = 1'b0; #1;
    chk("R1 reset pending readback", rdata, 8'h00);

    do_init(8'h00, 8'h20, 8'h04, 8'h01);
    // R4: masked request still latched, then drops with the line
    step(8'h10, 0, 0, 0, 0);
    step(8'h10, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0);
    // R3: unmask all, R5/R6 nesting
    step(8'h00, 1, 1, 8'h00, 0);
    step(8'h28, 0, 1, 0, 0);
    step(8'h28, 0, 0, 0, 1);       // R6: level 3 -> 0x23
    step(8'h28, 0, 0, 0, 0);       // R5: level 5 blocked by in-service 3
    step(8'h28, 1, 0, 8'h0B, 0);   // R8
    step(8'h28, 0, 0, 0, 0);
    step(8'h28, 1, 0, 8'h63, 0);   // R9
    step(8'h28, 0, 0, 0, 1);       // level 5
    step(8'h28, 1, 0, 8'h65, 0);
    step(8'h28, 1, 0, 8'h0A, 0);
    // R7: request withdrawn before acknowledge
    step(8'h29, 0, 0, 0, 0);
    step(8'h28, 0, 0, 0, 0);
    step(8'h28, 0, 0, 0, 1);
    // R10: automatic end-of-interrupt
    do_init(8'h00, 8'h48, 8'h02, 8'h03);
    step(8'h04, 0, 0, 0, 0);
    step(8'h04, 1, 0, 8'h0B, 0);
    step(8'h04, 0, 0, 0, 1);
    step(8'h04, 0, 0, 0, 0);

    do_init(8'h04, 8'h70, 8'h80, 8'h01);
    void'($urandom(32'h5EED));
    irq = 8'h04;
    for (int n = 0; n < 3000; n++) begin
      int act;
      irq = irq ^ ($urandom & $urandom & $urandom);
      act = $urandom % 8;
      case (act)
        0, 1: step(irq, 0, $urandom % 2, 0, 1);
        2:    step(irq, 1, 1, 8'($urandom & $urandom), 0);
        3:    step(irq, 1, 0, 8'h60 + 8'($urandom % 8), 0);
        4:    step(irq, 1, 0, ($urandom % 2) ? 8'h0B : 8'h0A, 0);
        default: step(irq, 0, $urandom % 2, 0, 0);
      endcase
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule